// File: doc/BRIEF.md
# Three-Axis Sensor Burst Sampler over I2C

This block is an I2C master sequencer that collects one three-axis acceleration sample from a sensor in a single combined bus transaction. A one-cycle start request launches the sequence. The block sends a START and the sensor address with the write bit, then the register pointer. It follows with a repeated START and the address with the read bit, then reads six data bytes back to back. The master acknowledges every data byte except the last one, which it leaves unacknowledged before the STOP.

The six received bytes are paired low/high into three signed-agnostic 16-bit axis words. All three words update together on a one-cycle valid pulse, and only when the whole transaction finished without a slave refusal. The block drives both bus lines through open-drain style pull-low controls and reads the data line back. A programmable divider sets the bit rate. If the sensor does not acknowledge any byte the master wrote, the transfer ends early with a STOP and an error flag.

Top module: `axis_burst_sampler`

## Requirements
- R1: After reset both pull-low controls are 0 (lines released), `busy`, `done`, `sampleValid` and `nakErr` are 0, and all three axis words are 0.
- R2: `startReq` is accepted only while `busy` is 0; a request while busy has no effect on the bus waveform or on the outcome of the running transaction.
- R3: A transaction runs START, byte 0x3A (address 0x1D shifted left with write bit 0), acknowledge slot, byte 0x31, acknowledge slot, repeated START with no STOP before it, byte 0x3B (address with read bit 1), acknowledge slot, six data bytes each with a ninth acknowledge slot, STOP. Bytes travel most significant bit first.
- R4: Every symbol takes four quarters of `QTR_CYCLES` clocks each. A bit is (SCL low, high, high, low) with SDA set at the start of the first quarter and sampled at the end of the third. START is (SCL low/SDA high, high/high, high/low, low/low). STOP is (low/low, high/low, high/high, high/high). SDA never changes while SCL stays high inside a bit, and the SCL period is 4*`QTR_CYCLES` clocks.
- R5: During data bits the master releases SDA. In the acknowledge slot it pulls SDA low after data bytes 0 to 4 and releases it after byte 5. In the acknowledge slots after the three written bytes it releases SDA.
- R6: If SDA reads high in the acknowledge slot of any written byte, the next symbol is STOP. The transaction then ends with a `done` pulse, `nakErr` set, no `sampleValid`, and the axis words unchanged. `nakErr` holds until the next accepted request.
- R7: Received bytes b0..b5 (reception order) form `axisX`={b1,b0}, `axisY`={b3,b2}, `axisZ`={b5,b4}. All three words change only in the cycle `sampleValid` is high.
- R8: `done` and `sampleValid` are single-cycle pulses in the clock after the last STOP quarter, and `busy` is 0 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | One-cycle request to fetch a sample |
| sdaIn | input | 1 | Level read back from the data line |
| sclLow | output | 1 | 1 pulls the clock line low, 0 releases it |
| sdaLow | output | 1 | 1 pulls the data line low, 0 releases it |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse when a transaction ends |
| sampleValid | output | 1 | One-cycle pulse when new axis words are published |
| nakErr | output | 1 | Last transaction was refused by the slave |
| axisX | output | 16 | X axis word |
| axisY | output | 16 | Y axis word |
| axisZ | output | 16 | Z axis word |

## Verification
A wrong state in the sequencer or divider shows up on the two pull-low controls within one quarter period. A miscounted bit or byte index shifts every later symbol, so a skipped acknowledge slot or a STOP in place of the repeated START disagrees with the expected waveform by the next clock. A fault in the receive shift path or byte store stays hidden on the bus and surfaces only when the words are published, one cycle after the final STOP quarter, as wrong axis values. That is why the data patterns put distinct values in every byte and both bit levels in every position.

// File: rtl/burst_pkg.sv
package burst_pkg;

  localparam int NUM_AXES    = 3;
  localparam int NUM_BYTES   = 2 * NUM_AXES;
  localparam int BYTE_IDX_W  = $clog2(NUM_BYTES);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_BIT,
    ST_STOP
  } busState_t;

  typedef enum logic [1:0] {
    SEG_ADDR_W,
    SEG_PTR,
    SEG_ADDR_R,
    SEG_DATA
  } segment_t;

  typedef enum logic [1:0] {
    TX_ADDR_W,
    TX_PTR,
    TX_ADDR_R
  } txSel_t;

  // strobes from the sequencer to the byte datapath
  typedef struct packed {
    logic                  loadTx;
    txSel_t                txSel;
    logic                  shiftTx;
    logic                  shiftRx;
    logic                  storeByte;
    logic [BYTE_IDX_W-1:0] byteIdx;
    logic                  publish;
  } dpStrobe_t;

endpackage

// File: rtl/burst_dp.sv
module burst_dp
  import burst_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h1D,
  parameter logic [7:0] REG_PTR  = 8'h31
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dpStrobe_t                    stb,
  input  logic                         sdaIn,
  output logic                         txBit,
  output logic [NUM_AXES-1:0][15:0]    axisWords
);

  logic [7:0] txShift;
  logic [7:0] rxShift;
  logic [7:0] byteReg [NUM_BYTES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (stb.loadTx) begin
      unique case (stb.txSel)
        TX_ADDR_W: txShift <= {DEV_ADDR, 1'b0};
        TX_PTR:    txShift <= REG_PTR;
        TX_ADDR_R: txShift <= {DEV_ADDR, 1'b1};
        default:   txShift <= '0;
      endcase
    end else if (stb.shiftTx) begin
      txShift <= {txShift[6:0], 1'b0};
    end
  end

  assign txBit = txShift[7];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
    end else if (stb.shiftRx) begin
      rxShift <= {rxShift[6:0], sdaIn};
    end
  end

  generate
    for (genvar b = 0; b < NUM_BYTES; b++) begin : gByte
      always_ff @(posedge clk) begin
        if (!rstN) begin
          byteReg[b] <= '0;
        end else if (stb.storeByte && (stb.byteIdx == BYTE_IDX_W'(b))) begin
          byteReg[b] <= rxShift;
        end
      end
    end
    for (genvar a = 0; a < NUM_AXES; a++) begin : gAxis
      always_ff @(posedge clk) begin
        if (!rstN) begin
          axisWords[a] <= '0;
        end else if (stb.publish) begin
          axisWords[a] <= {byteReg[2*a+1], byteReg[2*a]};
        end
      end
    end
  endgenerate

  AST_DP_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadTx, stb.shiftTx, stb.shiftRx, stb.storeByte, stb.publish})) else $error("datapath strobes overlap"); // R3

endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
#(
  parameter int QTR_CYCLES = 63
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      sdaIn,
  input  logic      txBit,
  output dpStrobe_t stb,
  output logic      sclLow,
  output logic      sdaLow,
  output logic      busy,
  output logic      done,
  output logic      sampleValid,
  output logic      nakErr
);

  localparam int DIV_W = (QTR_CYCLES > 2) ? $clog2(QTR_CYCLES) : 1;
  localparam logic [DIV_W-1:0]      DIV_LAST  = DIV_W'(QTR_CYCLES - 1);
  localparam logic [BYTE_IDX_W-1:0] BYTE_LAST = BYTE_IDX_W'(NUM_BYTES - 1);
  localparam logic [3:0]            ACK_SLOT  = 4'd8;

  busState_t             state;
  segment_t              seg;
  logic [1:0]            quarter;
  logic [DIV_W-1:0]      divCnt;
  logic [3:0]            bitIdx;
  logic [BYTE_IDX_W-1:0] byteIdx;
  logic                  slaveNak;
  logic                  abortReg;

  logic tick;
  logic symEnd;
  logic sampleEdge;
  logic inAck;

  assign busy       = (state != ST_IDLE);
  assign tick       = busy && (divCnt == DIV_LAST);
  assign symEnd     = tick && (quarter == 2'd3);
  assign sampleEdge = tick && (quarter == 2'd2);
  assign inAck      = (state == ST_BIT) && (bitIdx == ACK_SLOT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      seg         <= SEG_ADDR_W;
      quarter     <= '0;
      divCnt      <= '0;
      bitIdx      <= '0;
      byteIdx     <= '0;
      slaveNak    <= 1'b0;
      abortReg    <= 1'b0;
      done        <= 1'b0;
      sampleValid <= 1'b0;
      nakErr      <= 1'b0;
    end else begin
      done        <= 1'b0;
      sampleValid <= 1'b0;
      if (state == ST_IDLE) begin
        if (startReq) begin
          state    <= ST_START;
          seg      <= SEG_ADDR_W;
          quarter  <= '0;
          divCnt   <= '0;
          abortReg <= 1'b0;
          nakErr   <= 1'b0;
        end
      end else if (!tick) begin
        divCnt <= divCnt + 1'b1;
      end else begin
        divCnt  <= '0;
        quarter <= quarter + 1'b1;
        if (sampleEdge && inAck && (seg != SEG_DATA)) begin
          slaveNak <= sdaIn;
        end
        if (symEnd) begin
          unique case (state)
            ST_START: begin
              state  <= ST_BIT;
              bitIdx <= '0;
            end
            ST_BIT: begin
              if (bitIdx != ACK_SLOT) begin
                bitIdx <= bitIdx + 1'b1;
              end else begin
                bitIdx <= '0;
                unique case (seg)
                  SEG_ADDR_W: begin
                    if (slaveNak) begin state <= ST_STOP; abortReg <= 1'b1; end
                    else seg <= SEG_PTR;
                  end
                  SEG_PTR: begin
                    if (slaveNak) begin state <= ST_STOP; abortReg <= 1'b1; end
                    else begin state <= ST_START; seg <= SEG_ADDR_R; end
                  end
                  SEG_ADDR_R: begin
                    if (slaveNak) begin state <= ST_STOP; abortReg <= 1'b1; end
                    else begin seg <= SEG_DATA; byteIdx <= '0; end
                  end
                  default: begin
                    if (byteIdx == BYTE_LAST) state <= ST_STOP;
                    else byteIdx <= byteIdx + 1'b1;
                  end
                endcase
              end
            end
            ST_STOP: begin
              state       <= ST_IDLE;
              done        <= 1'b1;
              sampleValid <= !abortReg;
              nakErr      <= abortReg;
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end

  // strobes to the datapath
  always_comb begin
    stb           = '0;
    stb.txSel     = (seg == SEG_ADDR_R) ? TX_ADDR_R : TX_ADDR_W;
    stb.byteIdx   = byteIdx;
    if ((state == ST_START) && symEnd) begin
      stb.loadTx = 1'b1;
    end
    if (inAck && symEnd && (seg == SEG_ADDR_W) && !slaveNak) begin
      stb.loadTx = 1'b1;
      stb.txSel  = TX_PTR;
    end
    stb.shiftTx   = (state == ST_BIT) && symEnd && (bitIdx != ACK_SLOT) && (seg != SEG_DATA);
    stb.shiftRx   = (state == ST_BIT) && sampleEdge && (bitIdx != ACK_SLOT) && (seg == SEG_DATA);
    stb.storeByte = inAck && sampleEdge && (seg == SEG_DATA);
    stb.publish   = (state == ST_STOP) && symEnd && !abortReg;
  end

  // bus line controls, 1 = pull low
  always_comb begin
    sclLow = 1'b0;
    sdaLow = 1'b0;
    unique case (state)
      ST_START: begin
        sclLow = (quarter == 2'd0) || (quarter == 2'd3);
        sdaLow = quarter[1];
      end
      ST_BIT: begin
        sclLow = (quarter == 2'd0) || (quarter == 2'd3);
        if (bitIdx != ACK_SLOT) sdaLow = (seg != SEG_DATA) && !txBit;
        else                    sdaLow = (seg == SEG_DATA) && (byteIdx != BYTE_LAST);
      end
      ST_STOP: begin
        sclLow = (quarter == 2'd0);
        sdaLow = !quarter[1];
      end
      default: ;
    endcase
  end

  AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_BIT) && !sclLow && !$past(sclLow)) |-> $stable(sdaLow)) else $error("SDA moved with SCL high"); // R4
  AST_STOP_AFTER_REFUSAL: assert property (@(posedge clk) disable iff (!rstN)
    (inAck && symEnd && (seg != SEG_DATA) && slaveNak) |=> (state == ST_STOP)) else $error("no STOP after refusal"); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) else $error("done longer than one cycle"); // R8
  AST_VALID_EXCLUDES_ERR: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> (done && !nakErr && !busy)) else $error("valid with error or busy"); // R8
  AST_BUSY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startReq)) else $error("busy without request"); // R2

endmodule

// File: rtl/axis_burst_sampler.sv
module axis_burst_sampler
  import burst_pkg::*;
#(
  parameter int         QTR_CYCLES = 63,
  parameter logic [6:0] DEV_ADDR   = 7'h1D,
  parameter logic [7:0] REG_PTR    = 8'h31
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        sdaIn,
  output logic        sclLow,
  output logic        sdaLow,
  output logic        busy,
  output logic        done,
  output logic        sampleValid,
  output logic        nakErr,
  output logic [15:0] axisX,
  output logic [15:0] axisY,
  output logic [15:0] axisZ
);

  dpStrobe_t                     stb;
  logic                          txBit;
  logic [NUM_AXES-1:0][15:0]     axisWords;

  burst_ctrl #(.QTR_CYCLES(QTR_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .sdaIn(sdaIn), .txBit(txBit),
    .stb(stb), .sclLow(sclLow), .sdaLow(sdaLow), .busy(busy), .done(done),
    .sampleValid(sampleValid), .nakErr(nakErr)
  );

  burst_dp #(.DEV_ADDR(DEV_ADDR), .REG_PTR(REG_PTR)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaIn(sdaIn), .txBit(txBit),
    .axisWords(axisWords)
  );

  assign axisX = axisWords[0];
  assign axisY = axisWords[1];
  assign axisZ = axisWords[2];

  AST_AXES_MOVE_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |-> $stable({axisX, axisY, axisZ})) else $error("axis words changed without valid"); // R7

endmodule

// File: tb/tb_axis_burst_sampler.sv
module tb_axis_burst_sampler;

  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic slaveLow = 1'b0;
  logic sclLow, sdaLow, busy, done, sampleValid, nakErr;
  logic [15:0] axisX, axisY, axisZ;
  wire sdaIn = ~(sdaLow | slaveLow);

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  logic [2:0] plan [$];            // {expSclLow, expSdaLow, slavePull}
  logic [15:0] expX = '0, expY = '0, expZ = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  axis_burst_sampler #(.QTR_CYCLES(QTR)) dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .sdaIn(sdaIn),
    .sclLow(sclLow), .sdaLow(sdaLow), .busy(busy), .done(done),
    .sampleValid(sampleValid), .nakErr(nakErr),
    .axisX(axisX), .axisY(axisY), .axisZ(axisZ)
  );

  task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pushSym(input logic [1:0] s0, s1, s2, s3, input logic slv);
    plan.push_back({s0, slv});
    plan.push_back({s1, slv});
    plan.push_back({s2, slv});
    plan.push_back({s3, slv});
  endtask

  // quarter pairs are {sclLow, sdaLow}
  task automatic pushStart();  pushSym(2'b10, 2'b00, 2'b01, 2'b11, 1'b0); endtask
  task automatic pushStop();   pushSym(2'b11, 2'b01, 2'b00, 2'b00, 1'b0); endtask
  task automatic pushMasterBit(input logic v);
    pushSym({1'b1, !v}, {1'b0, !v}, {1'b0, !v}, {1'b1, !v}, 1'b0);
  endtask
  task automatic pushSlaveBit(input logic v);
    pushSym(2'b10, 2'b00, 2'b00, 2'b10, !v);
  endtask
  task automatic pushMasterByte(input logic [7:0] b);
    for (int k = 7; k >= 0; k--) pushMasterBit(b[k]);
  endtask

  // nakAt: -1 none, 0 address-write, 1 pointer, 2 address-read
  task automatic runTxn(input logic [47:0] bytes, input int nakAt, input bit poke);
    plan.delete();
    pushStart();
    pushMasterByte(8'h3A);
    pushSlaveBit(nakAt == 0);
    if (nakAt != 0) begin
      pushMasterByte(8'h31);
      pushSlaveBit(nakAt == 1);
      if (nakAt != 1) begin
        pushStart();
        pushMasterByte(8'h3B);
        pushSlaveBit(nakAt == 2);
        if (nakAt != 2) begin
          for (int i = 0; i < 6; i++) begin
            for (int k = 7; k >= 0; k--) pushSlaveBit(bytes[8*i + k]);
            pushMasterBit(i == 5);
          end
        end
      end
    end
    pushStop();

    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    for (int i = 0; i < plan.size(); i++) begin
      for (int c = 0; c < QTR; c++) begin
        slaveLow = plan[i][0];
        #1;
        check("R3 R4 R5 R6 bus lines", {46'd0, sclLow, sdaLow}, {46'd0, plan[i][2:1]});
        check("R2 busy during transfer", {47'd0, busy}, 48'd1);
        startReq = poke && (i == 40) && (c == 0);
        @(negedge clk);
      end
    end
    slaveLow = 1'b0;
    startReq = 1'b0;
    #1;
    if (nakAt < 0) begin
      expX = bytes[15:0];
      expY = bytes[31:16];
      expZ = bytes[47:32];
    end
    check("R8 done pulse", {47'd0, done}, 48'd1);
    check("R8 busy low at end", {47'd0, busy}, 48'd0);
    check("R6 R8 valid", {47'd0, sampleValid}, {47'd0, nakAt < 0});
    check("R6 error flag", {47'd0, nakErr}, {47'd0, nakAt >= 0});
    check("R7 axis words", {axisX, axisY, axisZ}, {expX, expY, expZ});
    @(negedge clk);
    #1;
    check("R8 done single cycle", {46'd0, done, sampleValid}, 48'd0);
    check("R6 error held", {47'd0, nakErr}, {47'd0, nakAt >= 0});
    check("R1 lines released when idle", {46'd0, sclLow, sdaLow}, 48'd0);
    check("R7 axis words held", {axisX, axisY, axisZ}, {expX, expY, expZ});
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset outputs", {40'd0, sclLow, sdaLow, busy, done, sampleValid, nakErr, 2'b00}, 48'd0);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check("R1 axes after reset", {axisX, axisY, axisZ}, 48'd0);
    check("R1 idle after reset", {43'd0, sclLow, sdaLow, busy, done, nakErr}, 48'd0);

    @(negedge clk);
    runTxn(48'hA5_3C_0F_F0_81_7E, -1, 1'b1);   // R2 request mid-transfer
    repeat (2) @(negedge clk);
    #1;
    check("R2 stays idle without request", {47'd0, busy}, 48'd0);
    runTxn(48'h00_FF_80_01_55_AA, -1, 1'b0);
    @(negedge clk);
    runTxn(48'h11_22_33_44_55_66, 0, 1'b0);    // R6 address-write refused
    @(negedge clk);
    runTxn(48'h11_22_33_44_55_66, 1, 1'b1);    // R6 pointer refused
    @(negedge clk);
    runTxn(48'h11_22_33_44_55_66, 2, 1'b0);    // R6 address-read refused
    @(negedge clk);
    runTxn(48'hFE_DC_BA_98_76_54, -1, 1'b0);   // R6 flag clears, R7 new words

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule